// File: doc/BRIEF.md
# Dual-Channel Output Lane Serializer

This block takes one parallel word from each of two channels, A and B, and shifts them out serially. The words go out on one or two data lanes. A 3-bit lane code chooses the arrangement. In the two-lane arrangements each channel has a lane of its own. In the one-lane arrangements channel A's word and then channel B's word are sent back to back on lane A. The lane code also sets the word length, which is either 20 or 24 bits per channel.

A separate rate control selects double-rate or single-rate output:
- In double-rate mode each internal clock carries two bits per lane. These appear as a rising-half bit and a falling-half bit.
- In single-rate mode each clock carries one bit per lane.

A bit-enable output marks the clocks that carry frame data. A frame marker flags the first clock of each frame.

The word pair enters through a valid/ready handshake. A pair is accepted on a clock where `in_valid` and `in_ready` are both high. The lane code and rate setting are captured on that same clock. `in_ready` stays low for the whole frame, so the next pair can be accepted no earlier than the clock after the frame's last bit clock. The source is not expected to hold `in_valid` through back-pressure. Any `in_valid` that arrives while `in_ready` is low is discarded. Such an arrival sets a sticky overrun flag, which only reset clears.

Top module: `lane_serializer`

## Requirements
- R1: After reset, `in_ready` is 1. `bit_en`, `frame_mark`, `overrun` and all four lane outputs are 0.
- R2: Lane code 0 sends channel A's low 20 bits on lane A and channel B's low 20 bits on lane B, MSB first.
- R3: Lane code 2 sends channel A's 24 bits on lane A and channel B's 24 bits on lane B, MSB first.
- R4: Lane code 5 sends 40 bits on lane A, MSB first: channel A's low 20 bits, then channel B's low 20 bits.
- R5: Lane code 7 sends 48 bits on lane A, MSB first: channel A's 24 bits, then channel B's 24 bits.
- R6: With `sdr_sel` = 0 (double rate), each bit clock carries two bits per lane. `*_rise` is the earlier bit and `*_fall` the later one. A frame of L bits per lane lasts L/2 clocks.
- R7: With `sdr_sel` = 1 (single rate), each bit clock carries one bit per lane on `*_rise`. `*_fall` equals `*_rise`. A frame lasts L clocks.
- R8: The first bit clock is the clock after acceptance. `bit_en` is high for exactly the frame's bit clocks. `frame_mark` is high on the first of them only.
- R9: In the one-lane codes (5 and 7), both lane B outputs stay 0 for the whole frame.
- R10: Lane codes 1, 3, 4 and 6 behave exactly as code 2.
- R11: An `in_valid` while a frame is in progress leaves that frame's bits and length unchanged. It sets `overrun`, which then stays 1 until reset.
- R12: Changes to `lane_code` or `sdr_sel` after acceptance have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_code | input | 3 | Lane arrangement and word length code |
| sdr_sel | input | 1 | 0 = double rate, 1 = single rate |
| in_valid | input | 1 | Word pair offered |
| in_ready | output | 1 | Serializer idle, pair will be accepted |
| chan_a | input | 24 | Channel A word (low 20 bits used in 20-bit codes) |
| chan_b | input | 24 | Channel B word (low 20 bits used in 20-bit codes) |
| lane_a_rise | output | 1 | Lane A, first bit of the clock |
| lane_a_fall | output | 1 | Lane A, second bit of the clock |
| lane_b_rise | output | 1 | Lane B, first bit of the clock |
| lane_b_fall | output | 1 | Lane B, second bit of the clock |
| bit_en | output | 1 | Lanes carry frame data this clock |
| frame_mark | output | 1 | First bit clock of a frame |
| overrun | output | 1 | Sticky: a word pair arrived during a frame |

## Verification
The assertions assume the following about the inputs:
- Every frame lasts at least two clocks, which holds for all legal word lengths.
- `lane_code` and `sdr_sel` are read only on the acceptance clock.

The stimulus drives every input away from the active edge and sweeps all eight lane codes with both rates and several data patterns. In the final frames it deliberately raises `in_valid` and changes the configuration in mid-frame, so that the overrun and capture rules are exercised after the clean sweep.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;

  typedef struct packed {
    logic one_lane;
    logic long_word;
  } lane_cfg_t;

  // codes 0/2 two lanes, 5/7 one lane; bit 1 set means long word;
  // anything unlisted maps to the two-lane long-word arrangement
  function automatic lane_cfg_t decode_lane_code(input logic [2:0] code);
    lane_cfg_t c;
    case (code)
      3'd0:    c = '{one_lane: 1'b0, long_word: 1'b0};
      3'd5:    c = '{one_lane: 1'b1, long_word: 1'b0};
      3'd7:    c = '{one_lane: 1'b1, long_word: 1'b1};
      default: c = '{one_lane: 1'b0, long_word: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lane_loader.sv
module lane_loader
  import lane_ser_pkg::*;
#(
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 20,
  parameter int SR_W    = 2 * LONG_W
) (
  input  logic [LONG_W-1:0] word_a,
  input  logic [LONG_W-1:0] word_b,
  input  lane_cfg_t         cfg,
  output logic [SR_W-1:0]   img_a,
  output logic [SR_W-1:0]   img_b
);
  localparam int SH_W = $clog2(SR_W + 1);
  localparam logic [LONG_W-1:0] SHORT_MASK = {LONG_W{1'b1}} >> (LONG_W - SHORT_W);

  logic [LONG_W-1:0] a_w, b_w;
  logic [SH_W-1:0]   w, top_sh;
  logic [SR_W-1:0]   a_top, b_top;

  always_comb begin
    a_w    = cfg.long_word ? word_a : (word_a & SHORT_MASK);
    b_w    = cfg.long_word ? word_b : (word_b & SHORT_MASK);
    w      = cfg.long_word ? SH_W'(LONG_W) : SH_W'(SHORT_W);
    top_sh = SH_W'(SR_W) - w;
    a_top  = SR_W'(a_w) << top_sh;
    b_top  = SR_W'(b_w) << top_sh;
    if (cfg.one_lane) begin
      img_a = a_top | (b_top >> w);
      img_b = '0;
    end else begin
      img_a = a_top;
      img_b = b_top;
    end
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int SR_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SR_W-1:0] img,
  input  logic            shift_en,
  input  logic            two_step,
  output logic            bit_rise,
  output logic            bit_fall
);
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (load)     sr <= img;
    else if (shift_en) sr <= two_step ? (sr << 2) : (sr << 1);
  end

  assign bit_rise = sr[SR_W-1];
  assign bit_fall = two_step ? sr[SR_W-2] : sr[SR_W-1];
endmodule

// File: rtl/lane_frame_ctrl.sv
module lane_frame_ctrl #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] frame_clocks,
  output logic             in_ready,
  output logic             accept,
  output logic             busy,
  output logic             frame_mark,
  output logic             overrun
);
  logic [CNT_W-1:0] remain;
  logic             first_q;

  assign busy       = (remain != '0);
  assign in_ready   = !busy;
  assign accept     = in_valid && in_ready;
  assign frame_mark = first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      first_q <= 1'b0;
      overrun <= 1'b0;
    end else begin
      first_q <= accept;
      if (accept)    remain <= frame_clocks;
      else if (busy) remain <= remain - 1'b1;
      if (in_valid && busy) overrun <= 1'b1;
    end
  end

  // R8
  mark_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |-> busy);
  // R8
  mark_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> frame_mark);
  // R8
  mark_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> !frame_mark);
  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> overrun);
  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        lane_code,
  input  logic              sdr_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LONG_W-1:0] chan_a,
  input  logic [LONG_W-1:0] chan_b,
  output logic              lane_a_rise,
  output logic              lane_a_fall,
  output logic              lane_b_rise,
  output logic              lane_b_fall,
  output logic              bit_en,
  output logic              frame_mark,
  output logic              overrun
);
  localparam int SR_W  = 2 * LONG_W;
  localparam int CNT_W = $clog2(SR_W + 1);
  localparam int NLANE = 2;

  lane_cfg_t        cfg_in;
  logic [CNT_W-1:0] lane_bits, frame_clocks;
  logic             accept, busy;
  logic             sdr_q, one_lane_q;
  logic [SR_W-1:0]  img   [NLANE];
  logic             rise  [NLANE];
  logic             fall  [NLANE];

  always_comb begin
    cfg_in    = decode_lane_code(lane_code);
    lane_bits = cfg_in.long_word ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
    if (cfg_in.one_lane) lane_bits = lane_bits << 1;
    frame_clocks = sdr_sel ? lane_bits : (lane_bits >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdr_q      <= 1'b0;
      one_lane_q <= 1'b0;
    end else if (accept) begin
      sdr_q      <= sdr_sel;
      one_lane_q <= cfg_in.one_lane;
    end
  end

  lane_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .frame_clocks (frame_clocks),
    .in_ready     (in_ready),
    .accept       (accept),
    .busy         (busy),
    .frame_mark   (frame_mark),
    .overrun      (overrun)
  );

  lane_loader #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .SR_W(SR_W)) u_load (
    .word_a (chan_a),
    .word_b (chan_b),
    .cfg    (cfg_in),
    .img_a  (img[0]),
    .img_b  (img[1])
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    lane_shifter #(.SR_W(SR_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .img      (img[g]),
      .shift_en (busy),
      .two_step (!sdr_q),
      .bit_rise (rise[g]),
      .bit_fall (fall[g])
    );
  end

  assign bit_en      = busy;
  assign lane_a_rise = busy & rise[0];
  assign lane_a_fall = busy & fall[0];
  assign lane_b_rise = busy & rise[1];
  assign lane_b_fall = busy & fall[1];

  // R9
  lane_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && one_lane_q) |-> (!lane_b_rise && !lane_b_fall));
  // R7
  sdr_halves_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sdr_q) |-> (lane_a_rise == lane_a_fall && lane_b_rise == lane_b_fall));
  // R1
  idle_lanes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> !(lane_a_rise || lane_a_fall || lane_b_rise || lane_b_fall));
endmodule

// File: tb/test_lane_serializer.sv
module test_lane_serializer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  lane_code = 3'd2;
  logic        sdr_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] chan_a = '0, chan_b = '0;
  logic        lane_a_rise, lane_a_fall, lane_b_rise, lane_b_fall;
  logic        bit_en, frame_mark, overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_serializer i_lane_serializer (
    .clk(clk), .rst_n(rst_n), .lane_code(lane_code), .sdr_sel(sdr_sel),
    .in_valid(in_valid), .in_ready(in_ready), .chan_a(chan_a), .chan_b(chan_b),
    .lane_a_rise(lane_a_rise), .lane_a_fall(lane_a_fall),
    .lane_b_rise(lane_b_rise), .lane_b_fall(lane_b_fall),
    .bit_en(bit_en), .frame_mark(frame_mark), .overrun(overrun)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run_frame(input logic [2:0] code, input logic sdr,
                           input logic [23:0] a, input logic [23:0] b,
                           input bit disturb);
    bit          one, lng;
    int          w, nbits, nclk, mark_err, en_err, half_err, bq_err;
    logic [23:0] a_w, b_w;
    logic [47:0] got_a, got_b, exp_a, exp_b;
    one   = (code == 3'd5) || (code == 3'd7);
    lng   = !((code == 3'd0) || (code == 3'd5));
    w     = lng ? 24 : 20;
    a_w   = lng ? a : (a & 24'hFFFFF);
    b_w   = lng ? b : (b & 24'hFFFFF);
    nbits = one ? 2 * w : w;
    nclk  = sdr ? nbits : nbits / 2;
    exp_a = one ? ((48'(a_w) << w) | 48'(b_w)) : 48'(a_w);
    exp_b = one ? 48'd0 : 48'(b_w);
    got_a = '0; got_b = '0;
    mark_err = 0; en_err = 0; half_err = 0; bq_err = 0;

    @(negedge clk);
    check("R8 ready before frame", 64'(in_ready), 64'd1);
    lane_code = code; sdr_sel = sdr; chan_a = a; chan_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < nclk; i++) begin
      if (disturb && i == 2) begin
        in_valid = 1'b1; lane_code = code ^ 3'b101; sdr_sel = !sdr;
        chan_a = ~a; chan_b = ~b;
      end
      if (disturb && i == 3) in_valid = 1'b0;
      if (bit_en !== 1'b1) en_err++;
      if (frame_mark !== (i == 0)) mark_err++;
      if (sdr) begin
        if (lane_a_fall !== lane_a_rise || lane_b_fall !== lane_b_rise) half_err++;
        got_a = {got_a[46:0], lane_a_rise};
        got_b = {got_b[46:0], lane_b_rise};
      end else begin
        got_a = {got_a[45:0], lane_a_rise, lane_a_fall};
        got_b = {got_b[45:0], lane_b_rise, lane_b_fall};
      end
      if (one && (lane_b_rise || lane_b_fall)) bq_err++;
      @(negedge clk);
    end
    check("R8 bit_en over frame length", 64'(en_err), 64'd0);
    check("R8 frame_mark first clock only", 64'(mark_err), 64'd0);
    check("R8 bit_en low after frame", 64'(bit_en), 64'd0);
    if (sdr) check("R7 fall mirrors rise", 64'(half_err), 64'd0);
    else     check("R6 double-rate stream order", 64'(got_a), 64'(exp_a));
    case (code)
      3'd0:    check("R2 lane A stream", 64'(got_a), 64'(exp_a));
      3'd5:    check("R4 lane A stream", 64'(got_a), 64'(exp_a));
      3'd7:    check("R5 lane A stream", 64'(got_a), 64'(exp_a));
      3'd2:    check("R3 lane A stream", 64'(got_a), 64'(exp_a));
      default: check("R10 unsupported code lane A", 64'(got_a), 64'(exp_a));
    endcase
    if (one) check("R9 lane B quiet", 64'(bq_err), 64'd0);
    else if (code == 3'd0 || code == 3'd2) check("R3 lane B stream", 64'(got_b), 64'(exp_b));
    else check("R10 unsupported code lane B", 64'(got_b), 64'(exp_b));
    if (disturb) begin
      check("R11 overrun set", 64'(overrun), 64'd1);
      check("R12 config capture stream", 64'(got_a), 64'(exp_a));
    end else if (!overrun_seen) begin
      check("R11 no overrun on clean frame", 64'(overrun), 64'd0);
    end
    lane_code = 3'd2; sdr_sel = 1'b0;
  endtask

  bit overrun_seen = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", 64'(in_ready), 64'd1);
    check("R1 outputs", 64'({bit_en, frame_mark, overrun,
          lane_a_rise, lane_a_fall, lane_b_rise, lane_b_fall}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'({bit_en, overrun, in_ready}), 64'd1);
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int s = 0; s < 2; s++) begin
          logic [23:0] a, b;
          a = 24'h9E3779 * 24'(p + c + 1) ^ 24'h800001;
          b = 24'h5BD1E9 * 24'(p * 3 + s + 2) ^ 24'hC00003;
          if (p == 2) begin a = 24'hFFFFFF; b = 24'h000001 << c; end
          run_frame(3'(c), s[0], a, b, 1'b0);
        end
      end
    end
    // R11 / R12 mid-frame disturbance, last so overrun stays clear before
    overrun_seen = 1;
    run_frame(3'd7, 1'b0, 24'hA5C3F1, 24'h3C96E7, 1'b1);
    run_frame(3'd0, 1'b1, 24'h123456, 24'hFEDCBA, 1'b1);
    run_frame(3'd5, 1'b1, 24'h0F0F0F, 24'hF0F0F0, 1'b1);
    check("R11 overrun sticky after frames", 64'(overrun), 64'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule